// File: doc/BRIEF.md
# Half-Bridge Dead-Time Gate Pulse Generator

This block converts one PWM command into a pair of complementary gate enables, one for the high-side switch and one for the low-side switch of a half bridge. Whenever the command changes direction, the block turns the conducting side off first. It holds both enables low for a fixed non-overlap gap, and only then turns the other side on. The gap is one of four preset lengths, and every length is counted in cycles of the reference clock.

The preset is picked from a digitised select level. The level is compared against three thresholds, and the band it falls in gives a 2-bit code. The code is captured only while the block is parked in its off state. For this reason the gap length never changes while the bridge is switching. A synchronous shutdown request, or either of two supply-good flags going low, parks the block with both enables low. Switching resumes, starting with a fresh gap, only after the shutdown request is gone and both supplies are good.

The controller has four states. ST_OFF is the parked state. ST_GAP holds both enables low while the gap is counted. ST_HIGH_ON drives the high-side enable and ST_LOW_ON drives the low-side enable. Its transitions are:
- T_WAKE: ST_OFF to ST_GAP, with the target side taken from the PWM level.
- T_RETARGET: ST_GAP to ST_GAP, with the count restarted for the new direction.
- T_EXPIRE_HI and T_EXPIRE_LO: ST_GAP to the target on-state.
- T_HIGH_RELEASE and T_LOW_RELEASE: an on-state back to ST_GAP.
- T_FAULT: any state to ST_OFF.

Top module: `hbdt_gate_driver`

## Requirements
- R1: While reset is asserted and after it is released, both gate enables are low and the preset code reads 0.
- R2: With 8-bit select levels, a level below 59 gives code 0, a level from 59 to 91 gives code 1, a level from 92 to 145 gives code 2, and a level of 146 or more gives code 3. The code appears on `dt_mode` one edge after it is sampled.
- R3: With the default 25 ns reference period, codes 0, 1, 2 and 3 give gaps of 1, 2, 3 and 5 clock cycles, which are 25, 45, 75 and 105 ns rounded up.
- R4: A rising PWM while the low side is on drops `gate_lo` at the next edge. `gate_hi` then rises exactly the preset number of cycles after `gate_lo` fell.
- R5: A falling PWM while the high side is on drops `gate_hi` at the next edge. `gate_lo` then rises exactly the preset number of cycles after `gate_hi` fell.
- R6: If PWM changes during a gap, the gap count restarts for the new direction. Both enables are never high in the same cycle.
- R7: A shutdown request forces both enables low at the next edge and holds them low. After release, a full gap runs before the side selected by PWM turns on.
- R8: If either supply-good flag is low, both enables go low at the next edge and stay low. Switching resumes only when both flags are high.
- R9: The preset code is sampled only in the parked state. Changes to the select level while switching affect neither `dt_mode` nor the gap length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM command, 1 means the high side should conduct |
| sel_level | input | 8 | Digitised select level for the preset band |
| shutdown | input | 1 | Synchronous shutdown request, active high |
| supply_a_ok | input | 1 | First supply above its undervoltage threshold |
| supply_b_ok | input | 1 | Second supply above its undervoltage threshold |
| gate_hi | output | 1 | Registered high-side gate enable |
| gate_lo | output | 1 | Registered low-side gate enable |
| dt_mode | output | 2 | Latched preset code |

## Verification
A wrong controller state shows on the gate enables within one cycle, because the enables are registered directly from the next state. A miscounted gap shows as an early or late turn-on at the first transition after the error. A wrongly latched band code shows at once on `dt_mode`, and later as a wrong gap length. The bench model predicts both enables and the code on every cycle, so any of these errors is reported in the cycle where it first becomes visible.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_GAP     = 2'd1,
        ST_HIGH_ON = 2'd2,
        ST_LOW_ON  = 2'd3
    } hb_state_e;

    // Cycles needed to cover a span, rounded up, never below one.
    function automatic int unsigned gap_cycles(input int unsigned span_ps,
                                               input int unsigned period_ps);
        int unsigned c;
        c = (span_ps + period_ps - 1) / period_ps;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/hbdt_preset_sel.sv
module hbdt_preset_sel #(
    parameter int unsigned LVL_W = 8,
    parameter int unsigned TH_A  = 59,
    parameter int unsigned TH_B  = 92,
    parameter int unsigned TH_C  = 146,
    parameter int unsigned CNT_W = 3,
    parameter int unsigned GAP0  = 1,
    parameter int unsigned GAP1  = 2,
    parameter int unsigned GAP2  = 3,
    parameter int unsigned GAP3  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic [LVL_W-1:0] level,
    output logic [1:0]       mode_q,
    output logic [CNT_W-1:0] limit
);
    localparam int unsigned N_TH = 3;
    localparam int unsigned TH_TAB [N_TH] = '{TH_A, TH_B, TH_C};

    logic [N_TH-1:0] above;
    logic [1:0]      band_d;

    // One comparator per threshold; the band is the number of thresholds met.
    for (genvar i = 0; i < N_TH; i++) begin : g_cmp
        assign above[i] = ({1'b0, level} >= (LVL_W + 1)'(TH_TAB[i]));
    end

    assign band_d = 2'(above[0]) + 2'(above[1]) + 2'(above[2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 2'd0;
        end else if (sample_en) begin
            mode_q <= band_d;
        end
    end

    always_comb begin
        unique case (mode_q)
            2'd0:    limit = CNT_W'(GAP0);
            2'd1:    limit = CNT_W'(GAP1);
            2'd2:    limit = CNT_W'(GAP2);
            default: limit = CNT_W'(GAP3);
        endcase
    end

endmodule

// File: rtl/hbdt_interval_timer.sv
module hbdt_interval_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (cnt_q != {CNT_W{1'b1}}) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // The count holds the number of gap cycles already spent.
    assign expired = (cnt_q == (limit - CNT_W'(1)));

endmodule

// File: rtl/hbdt_gate_fsm.sv
module hbdt_gate_fsm
    import hbdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_ok,
    input  logic pwm,
    input  logic gap_done,
    output logic timer_clear,
    output logic sample_en,
    output logic gate_hi,
    output logic gate_lo
);
    hb_state_e state_q, state_d;
    logic      dir_q, dir_d;
    logic      retarget;

    always_comb begin
        state_d  = state_q;
        dir_d    = dir_q;
        retarget = 1'b0;
        if (!run_ok) begin
            state_d = ST_OFF;                          // T_FAULT
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_GAP;                  // T_WAKE
                    dir_d   = pwm;
                end
                ST_GAP: begin
                    if (pwm != dir_q) begin
                        dir_d    = pwm;                // T_RETARGET
                        retarget = 1'b1;
                    end else if (gap_done) begin
                        state_d = dir_q ? ST_HIGH_ON   // T_EXPIRE_HI
                                        : ST_LOW_ON;   // T_EXPIRE_LO
                    end
                end
                ST_HIGH_ON: begin
                    if (!pwm) begin
                        state_d = ST_GAP;              // T_HIGH_RELEASE
                        dir_d   = 1'b0;
                    end
                end
                ST_LOW_ON: begin
                    if (pwm) begin
                        state_d = ST_GAP;              // T_LOW_RELEASE
                        dir_d   = 1'b1;
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    assign timer_clear = !((state_q == ST_GAP) && (state_d == ST_GAP) && !retarget);
    assign sample_en   = (state_q == ST_OFF);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            dir_q   <= dir_d;
        end
    end

    // Registered gate outputs follow the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
        end else begin
            gate_hi <= (state_d == ST_HIGH_ON);
            gate_lo <= (state_d == ST_LOW_ON);
        end
    end

endmodule

// File: rtl/hbdt_gate_driver.sv
module hbdt_gate_driver #(
    parameter int unsigned LVL_W         = 8,
    parameter int unsigned TH_A          = 59,
    parameter int unsigned TH_B          = 92,
    parameter int unsigned TH_C          = 146,
    parameter int unsigned REF_PERIOD_PS = 25000,
    parameter int unsigned DT0_PS        = 25000,
    parameter int unsigned DT1_PS        = 45000,
    parameter int unsigned DT2_PS        = 75000,
    parameter int unsigned DT3_PS        = 105000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_in,
    input  logic [LVL_W-1:0] sel_level,
    input  logic             shutdown,
    input  logic             supply_a_ok,
    input  logic             supply_b_ok,
    output logic             gate_hi,
    output logic             gate_lo,
    output logic [1:0]       dt_mode
);
    localparam int unsigned GAP0    = hbdt_pkg::gap_cycles(DT0_PS, REF_PERIOD_PS);
    localparam int unsigned GAP1    = hbdt_pkg::gap_cycles(DT1_PS, REF_PERIOD_PS);
    localparam int unsigned GAP2    = hbdt_pkg::gap_cycles(DT2_PS, REF_PERIOD_PS);
    localparam int unsigned GAP3    = hbdt_pkg::gap_cycles(DT3_PS, REF_PERIOD_PS);
    localparam int unsigned GAP_MAX = hbdt_pkg::max_of4(GAP0, GAP1, GAP2, GAP3);
    localparam int unsigned CNT_W   = $clog2(GAP_MAX + 1);

    logic             run_ok;
    logic             sample_en;
    logic             timer_clear;
    logic             gap_done;
    logic [CNT_W-1:0] gap_limit;

    assign run_ok = !shutdown && supply_a_ok && supply_b_ok;

    hbdt_preset_sel #(
        .LVL_W(LVL_W), .TH_A(TH_A), .TH_B(TH_B), .TH_C(TH_C), .CNT_W(CNT_W),
        .GAP0(GAP0), .GAP1(GAP1), .GAP2(GAP2), .GAP3(GAP3)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_en(sample_en),
        .level    (sel_level),
        .mode_q   (dt_mode),
        .limit    (gap_limit)
    );

    hbdt_interval_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (timer_clear),
        .limit  (gap_limit),
        .expired(gap_done)
    );

    hbdt_gate_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_ok     (run_ok),
        .pwm        (pwm_in),
        .gap_done   (gap_done),
        .timer_clear(timer_clear),
        .sample_en  (sample_en),
        .gate_hi    (gate_hi),
        .gate_lo    (gate_lo)
    );

endmodule

// File: rtl/hbdt_gate_checker.sv
module hbdt_gate_checker #(
    parameter int unsigned REF_PERIOD_PS = 25000,
    parameter int unsigned DT0_PS        = 25000,
    parameter int unsigned DT1_PS        = 45000,
    parameter int unsigned DT2_PS        = 75000,
    parameter int unsigned DT3_PS        = 105000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pwm_in,
    input logic       shutdown,
    input logic       supply_a_ok,
    input logic       supply_b_ok,
    input logic       gate_hi,
    input logic       gate_lo,
    input logic [1:0] dt_mode
);
    logic [7:0]  low_run;
    int unsigned need;

    always_comb begin
        unique case (dt_mode)
            2'd0:    need = hbdt_pkg::gap_cycles(DT0_PS, REF_PERIOD_PS);
            2'd1:    need = hbdt_pkg::gap_cycles(DT1_PS, REF_PERIOD_PS);
            2'd2:    need = hbdt_pkg::gap_cycles(DT2_PS, REF_PERIOD_PS);
            default: need = hbdt_pkg::gap_cycles(DT3_PS, REF_PERIOD_PS);
        endcase
    end

    // Counts consecutive cycles in which both enables were low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_run <= 8'd0;
        else if (gate_hi || gate_lo) low_run <= 8'd0;
        else if (low_run != 8'hFF) low_run <= low_run + 8'd1;
    end

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    assert_shutdown_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (!gate_hi && !gate_lo));

    assert_supply_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_a_ok || !supply_b_ok) |=> (!gate_hi && !gate_lo));

    assert_hi_after_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> ($past(pwm_in) && !$past(gate_lo)));

    assert_lo_after_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> (!$past(pwm_in) && !$past(gate_hi)));

    assert_gap_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_hi) || $rose(gate_lo)) |-> (32'(low_run) >= need));

    assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi || gate_lo) |=> $stable(dt_mode));

endmodule

bind hbdt_gate_driver hbdt_gate_checker #(
    .REF_PERIOD_PS(REF_PERIOD_PS),
    .DT0_PS(DT0_PS), .DT1_PS(DT1_PS), .DT2_PS(DT2_PS), .DT3_PS(DT3_PS)
) u_hbdt_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_in     (pwm_in),
    .shutdown   (shutdown),
    .supply_a_ok(supply_a_ok),
    .supply_b_ok(supply_b_ok),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo),
    .dt_mode    (dt_mode)
);

// File: tb/hbdt_gate_driver_bench.sv
module hbdt_gate_driver_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_in = 1'b0;
    logic [7:0] sel_level = 8'd30;
    logic       shutdown = 1'b1;
    logic       supply_a_ok = 1'b1;
    logic       supply_b_ok = 1'b1;
    logic       gate_hi, gate_lo;
    logic [1:0] dt_mode;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    always #10 clk = ~clk;

    hbdt_gate_driver u_hbdt_gate_driver (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .sel_level(sel_level),
        .shutdown(shutdown), .supply_a_ok(supply_a_ok), .supply_b_ok(supply_b_ok),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .dt_mode(dt_mode)
    );

    // Expected band code (R2) and gap cycles (R3).
    function automatic int exp_code(input int v);
        if (v < 59)  return 0;
        if (v < 92)  return 1;
        if (v < 146) return 2;
        return 3;
    endfunction

    function automatic int exp_gap(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 3;
            default: return 5;
        endcase
    endfunction

    // Behavioural model: 0 parked, 1 gap, 2 high on, 3 low on.
    int m_st, m_cnt, m_dir, m_mode;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_dir = 0; m_mode = 0;
        end else begin
            int st_now;
            st_now = m_st;
            if (st_now == 0) m_mode = exp_code(int'(sel_level));
            if (shutdown || !supply_a_ok || !supply_b_ok) begin
                m_st = 0;
            end else if (st_now == 0) begin
                m_st = 1; m_dir = int'(pwm_in); m_cnt = 0;
            end else if (st_now == 1) begin
                if (int'(pwm_in) != m_dir) begin
                    m_dir = int'(pwm_in); m_cnt = 0;
                end else if (m_cnt + 1 >= exp_gap(m_mode)) begin
                    m_st = (m_dir == 1) ? 2 : 3;
                end else begin
                    m_cnt++;
                end
            end else if (st_now == 2 && !pwm_in) begin
                m_st = 1; m_dir = 0; m_cnt = 0;
            end else if (st_now == 3 && pwm_in) begin
                m_st = 1; m_dir = 1; m_cnt = 0;
            end
        end
    end

    task automatic check_bit(input string what, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s got %0b expected %0b at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            check_bit("gate_hi", gate_hi, m_st == 2);
            check_bit("gate_lo", gate_lo, m_st == 3);
            n_cmp++;
            if (dt_mode !== 2'(m_mode)) begin
                n_bad++;
                $display("FAIL %s dt_mode got %0d expected %0d at %0t", cur_req, dt_mode, m_mode, $time);
            end
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic random_pwm(input int cycles);
        int left;
        left = cycles;
        while (left > 0) begin
            int h;
            h = int'($urandom_range(1, 7));
            pwm_in = ~pwm_in;
            hold(h);
            left -= h;
        end
    endtask

    initial begin
        // R1: reset state
        hold(3);
        rst_n = 1'b1;
        hold(4);

        // R2 R3 R4 R5: code 0, one-cycle gap
        cur_req = "R4";
        shutdown = 1'b0; pwm_in = 1'b0; hold(6);
        pwm_in = 1'b1; hold(6);
        cur_req = "R5";
        pwm_in = 1'b0; hold(6);

        // R9: select level changes while switching are ignored
        cur_req = "R9";
        sel_level = 8'd200;
        pwm_in = 1'b1; hold(5); pwm_in = 1'b0; hold(5); pwm_in = 1'b1; hold(5);

        // R7: shutdown, then restart with code 3 (five-cycle gap)
        cur_req = "R7";
        shutdown = 1'b1; hold(5);
        shutdown = 1'b0; hold(10);
        cur_req = "R5";
        pwm_in = 1'b0; hold(9);

        // R6: PWM changes inside a gap restart it
        cur_req = "R6";
        pwm_in = 1'b1; hold(2); pwm_in = 1'b0; hold(2); pwm_in = 1'b1; hold(3);
        pwm_in = 1'b0; hold(1); pwm_in = 1'b1; hold(9);

        // R8: each supply flag on its own
        cur_req = "R8";
        supply_a_ok = 1'b0; hold(4); pwm_in = 1'b0; hold(2);
        supply_a_ok = 1'b1; hold(9);
        supply_b_ok = 1'b0; pwm_in = 1'b1; hold(3);
        supply_b_ok = 1'b1; hold(9);
        supply_a_ok = 1'b0; supply_b_ok = 1'b0; hold(3);
        supply_a_ok = 1'b1; hold(3);
        supply_b_ok = 1'b1; hold(9);

        // R2 R3: band boundaries, each followed by switching
        cur_req = "R2";
        foreach (sel_tab[i]) begin
            shutdown = 1'b1; hold(2);
            sel_level = sel_tab[i]; hold(2);
            shutdown = 1'b0;
            cur_req = "R3";
            random_pwm(40);
            cur_req = "R2";
        end

        // R6 R7 R8: long random run with occasional faults
        cur_req = "R6";
        for (int k = 0; k < 60; k++) begin
            random_pwm(30);
            case ($urandom_range(0, 3))
                0: begin cur_req = "R7"; shutdown = 1'b1; sel_level = 8'($urandom); hold(3); shutdown = 1'b0; end
                1: begin cur_req = "R8"; supply_a_ok = 1'b0; hold(2); supply_a_ok = 1'b1; end
                2: begin cur_req = "R8"; supply_b_ok = 1'b0; hold(2); supply_b_ok = 1'b1; end
                default: begin cur_req = "R9"; sel_level = 8'($urandom); end
            endcase
            cur_req = "R6";
        end

        hold(2);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    logic [7:0] sel_tab [10] = '{8'd58, 8'd59, 8'd91, 8'd92, 8'd145, 8'd146, 8'd0, 8'd255, 8'd70, 8'd120};

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule